// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a byte-wide SPI master that software runs through five small registers: configuration, control, clock divider, data and status. A write to the data register queues one byte in a single-entry transmit buffer. The shift engine takes that byte as soon as it is idle and runs eight SCK cycles. While it shifts the byte out, it shifts a byte in, and the byte it receives goes into a three-entry receive FIFO. When the input direction is selected, a read of the data register also queues a dummy byte of 0xFF. This lets software receive a stream by reading alone.

SCK is the system clock divided by a programmable value. Either clock mode 0 (SCK idles low) or mode 3 (SCK idles high) can be chosen. The block always samples incoming data on the rising edge of SCK, and outgoing data changes on the falling edge. Full-duplex operation uses SCK, MOSI and MISO. In two-wire half-duplex operation MOSI is dropped and MISO is the only data pin. Bit order is selectable. Chip select is not part of this block; software drives it from a general I/O pin.

Register map (3-bit address): 0 = configuration (bit 4 interrupt enable, bit 3 LSB-first). 1 = control: bit 7 MISO output enable, bit 6 MOSI output enable, bit 5 SCK output enable, bit 4 input direction, bit 3 clock mode, bit 2 two-wire, bit 1 clear-all, bit 0 auto-clear. 2 = divider. 3 = data. 4 = status: bit 4 byte-done (write 1 to clear), bit 3 idle, bit 2 transmit count, bits 1:0 receive count.

Top module: `spi_master_regs`

## Requirements
- R1: While no byte is shifting, sck_o equals control bit 3. A value of 0 gives mode 0 (SCK idles low) and a value of 1 gives mode 3 (SCK idles high).
- R2: The block captures MISO once per bit, on the rising SCK edge. Bits are assembled MSB-first when configuration bit 3 is 0 and LSB-first when it is 1, and the assembled byte is read back from address 3.
- R3: One SCK period lasts D system clocks. D is the divider register (reset 0x20); a divider value of 0 or 1 is treated as 2.
- R4: A write to address 3 starts a transfer of the written byte. When control bit 4 is 1 and the transmit buffer is empty, a read of address 3 queues 0xFF and starts a transfer. When control bit 4 is 0, a read starts nothing.
- R5: Status bit 2 shows whether the one-byte transmit buffer is occupied. Status bits 1:0 hold the receive FIFO count (0 to 3). Bytes are read in arrival order. A byte that completes while the FIFO holds 3 is dropped.
- R6: Status bit 3 is 1 whenever no bit is being shifted, including the gap between bytes. It is 0 during a transfer, and it resets to 1.
- R7: Status bit 4 sets at the end of every byte. It clears when 1 is written to bit 4 of address 4. When control bit 0 is 1, any read or write of address 3 also clears it. irq equals this flag ANDed with configuration bit 4.
- R8: Control resets to 0x02. While control bit 1 is 1, both buffers read empty, the byte-done flag stays 0 and no transfer starts.
- R9: MOSI carries the transmitted byte in the selected bit order. It is stable while SCK is high and changes only at the start of each bit, when SCK is low.
- R10: sck_oe and miso_oe follow control bits 5 and 7. mosi_oe follows control bit 6 but is forced to 0 when control bit 2 (two-wire) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Byte-done interrupt |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out on the MISO pad for two-wire use |
| miso_oe | output | 1 | MISO output enable |

## Verification
The case hardest to reach is a byte completing while the receive FIFO already holds three bytes. To reach it, the bench queues four whole transfers without reading and then drains the FIFO, checking both the order of the bytes and the loss of the fourth. The boundary between read-launched and write-launched transfers is checked the same way. A read made with the input direction set must move 0xFF onto MOSI. A read made with the output direction set must leave the idle flag high. All of this runs inside a sweep over both clock modes, both bit orders and several divider values, including the clamped ones.

// File: rtl/spi_master_regs.sv
`timescale 1ns/1ps
module spi_master_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       sck_o,
  output logic       sck_oe,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe
);
  localparam logic [2:0] A_CFG = 3'd0, A_CTL = 3'd1, A_DIV = 3'd2, A_DATA = 3'd3, A_STAT = 3'd4;

  logic [1:0] cfg;
  logic [7:0] ctl, div;
  logic       txv;
  logic [7:0] txb;
  logic       busy, samp, done;
  logic [7:0] cnt, sh;
  logic [2:0] bitn;
  logic [7:0] rxm [3];
  logic [1:0] rx_wp, rx_rp, rx_cnt;

  function automatic logic [1:0] inc3(input logic [1:0] p);
    return (p == 2'd2) ? 2'd0 : p + 2'd1;
  endfunction

  wire       clr     = ctl[1];
  wire       lsb     = cfg[0];
  wire [7:0] dv      = (div < 8'd2) ? 8'd2 : div;
  wire [7:0] half    = {1'b0, dv[7:1]};
  wire       wr_data = reg_wr && reg_addr == A_DATA;
  wire       rd_data = reg_rd && !reg_wr && reg_addr == A_DATA;
  wire       bit_end = busy && cnt == dv - 8'd1;
  wire       last    = bit_end && bitn == 3'd7;
  wire       start   = !busy && txv && !clr;
  wire       out_bit = lsb ? sh[0] : sh[7];
  wire [7:0] nxt     = lsb ? {samp, sh[7:1]} : {sh[6:0], samp};
  wire       push    = last && !clr && rx_cnt != 2'd3;
  wire       pop     = rd_data && !clr && rx_cnt != 2'd0;

  assign sck_o   = busy ? (cnt >= half) : ctl[3];
  assign mosi_o  = busy ? out_bit : 1'b1;
  assign miso_o  = mosi_o;
  assign sck_oe  = ctl[5];
  assign miso_oe = ctl[7];
  assign mosi_oe = ctl[6] && !ctl[2];
  assign irq     = done && cfg[1];

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {3'b0, cfg[1], cfg[0], 3'b0};
      A_CTL:   reg_rdata = ctl;
      A_DIV:   reg_rdata = div;
      A_DATA:  reg_rdata = rxm[rx_rp];
      A_STAT:  reg_rdata = {3'b0, done, !busy, txv, rx_cnt};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= 2'b00;
      ctl <= 8'h02;
      div <= 8'h20;
    end else if (reg_wr) begin
      if (reg_addr == A_CFG) cfg <= reg_wdata[4:3];
      if (reg_addr == A_CTL) ctl <= reg_wdata;
      if (reg_addr == A_DIV) div <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txv <= 1'b0;
      txb <= 8'h00;
    end else if (clr) begin
      txv <= 1'b0;
    end else if (wr_data) begin
      txv <= 1'b1;
      txb <= reg_wdata;
    end else if (rd_data && ctl[4] && !txv) begin
      txv <= 1'b1;
      txb <= 8'hFF;
    end else if (start) begin
      txv <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= 8'd0;
      bitn <= 3'd0;
      sh   <= 8'd0;
      samp <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= 8'd0;
      bitn <= 3'd0;
      sh   <= txb;
    end else if (busy) begin
      if (cnt == half - 8'd1) samp <= miso_i;
      if (bit_end) begin
        cnt  <= 8'd0;
        sh   <= nxt;
        bitn <= bitn + 3'd1;
        if (bitn == 3'd7) busy <= 1'b0;
      end else begin
        cnt <= cnt + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else if (clr) done <= 1'b0;
    else if (last) done <= 1'b1;
    else if ((reg_wr && reg_addr == A_STAT && reg_wdata[4]) ||
             (ctl[0] && (wr_data || rd_data))) done <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (push) rxm[rx_wp] <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp  <= 2'd0;
      rx_rp  <= 2'd0;
      rx_cnt <= 2'd0;
    end else if (clr) begin
      rx_wp  <= 2'd0;
      rx_rp  <= 2'd0;
      rx_cnt <= 2'd0;
    end else begin
      if (push) rx_wp <= inc3(rx_wp);
      if (pop)  rx_rp <= inc3(rx_rp);
      rx_cnt <= rx_cnt + 2'(push) - 2'(pop);
    end
  end

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sck_o == ctl[3]); // R1
  AST_PENDING_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && txv && !clr) |=> busy); // R4
  AST_RX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == 2'd3 && !rd_data && !clr) |=> rx_cnt == 2'd3); // R5
  AST_DONE_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !clr) |=> done); // R7
  AST_CLR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rx_cnt == 2'd0 && !txv && !done)); // R8
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sck_o && $past(sck_o)) |-> $stable(mosi_o)); // R9
endmodule

// File: tb/spi_master_regs_bench.sv
`timescale 1ns/1ps
module spi_master_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, miso_i = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  int nvec = 0, nbad = 0;

  always #10 clk = ~clk;

  spi_master_regs u_spi_master_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe));

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #2 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] mtx, input logic [7:0] stx, input bit lsb,
                      input bit by_read, output logic [7:0] srx, output int per);
    time t0, t1;
    logic [7:0] s;
    t0 = 0; t1 = 0; srx = 8'h00;
    miso_i = lsb ? stx[0] : stx[7];
    fork
      begin
        if (by_read) rd(3'd3, s); else wr(3'd3, mtx);
      end
      begin
        for (int k = 0; k < 8; k++) begin
          @(posedge sck_o);
          if (k == 0) t0 = $time;
          if (k == 1) t1 = $time;
          if (lsb) srx[k] = mosi_o; else srx[7-k] = mosi_o;
          if (k < 7) #1 miso_i = lsb ? stx[k+1] : stx[6-k];
        end
      end
    join
    per = int'((t1 - t0) / 20);
    do rd(3'd4, s); while (!(s[3] && !s[2]));
  endtask

  initial begin
    #(200000 * 20);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [7:0] r, srx, mtx, stx;
    int per, d, idx;
    int dvs[5] = '{0, 1, 2, 3, 5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd4, r); check("R6 reset status", r, 8'h08);
    rd(3'd1, r); check("R8 reset control", r, 8'h02);
    rd(3'd2, r); check("R3 reset divider", r, 8'h20);
    check("R1 reset sck", sck_o, 0);
    check("R7 reset irq", irq, 0);

    idx = 0;
    for (int m = 0; m < 2; m++)
      for (int l = 0; l < 2; l++)
        for (int di = 0; di < 5; di++) begin
          wr(3'd1, 8'hE0 | 8'(m << 3));
          wr(3'd0, 8'h10 | 8'(l << 3));
          wr(3'd2, 8'(dvs[di]));
          d = dvs[di] < 2 ? 2 : dvs[di];
          check("R1 idle level", sck_o, m);
          check("R10 mosi_oe three-wire", mosi_oe, 1);
          mtx = 8'hA5 ^ 8'(idx * 37);
          stx = 8'h3C + 8'(idx * 29);
          idx++;
          xfer(mtx, stx, l[0], 1'b0, srx, per);
          check("R9 mosi byte", srx, mtx);
          check("R3 sck period", per, d);
          check("R1 idle level after byte", sck_o, m);
          rd(3'd4, r); check("R7 done set", r[4], 1);
          check("R7 irq", irq, 1);
          rd(3'd3, r); check("R2 miso byte", r, stx);
          wr(3'd4, 8'h10);
          rd(3'd4, r); check("R7 write-one clear", r, 8'h08);
        end

    wr(3'd0, 8'h00); wr(3'd2, 8'd4); wr(3'd1, 8'hE0);
    wr(3'd3, 8'h11); wr(3'd3, 8'h22);
    rd(3'd4, r);
    check("R5 tx count while busy", r[2], 1);
    check("R6 idle low while busy", r[3], 0);
    do rd(3'd4, r); while (!(r[3] && !r[2]));
    check("R5 rx count two", r[1:0], 2);
    rd(3'd3, r); rd(3'd3, r);

    xfer(8'h01, 8'h81, 1'b0, 1'b0, srx, per);
    xfer(8'h02, 8'h42, 1'b0, 1'b0, srx, per);
    xfer(8'h03, 8'h24, 1'b0, 1'b0, srx, per);
    xfer(8'h04, 8'h18, 1'b0, 1'b0, srx, per);
    rd(3'd4, r); check("R5 rx full count", r[1:0], 3);
    rd(3'd3, r); check("R5 order first", r, 8'h81);
    rd(3'd3, r); check("R5 order second", r, 8'h42);
    rd(3'd3, r); check("R5 order third, fourth dropped", r, 8'h24);
    rd(3'd4, r); check("R5 rx drained", r[1:0], 0);

    check("R7 done before auto-clear", r[4], 1);
    wr(3'd1, 8'hE1);
    rd(3'd3, r);
    rd(3'd4, r); check("R7 auto-clear on data access", r[4], 0);

    wr(3'd1, 8'hF0);
    xfer(8'h00, 8'h5A, 1'b0, 1'b1, srx, per);
    check("R4 read launch sends FF", srx, 8'hFF);
    rd(3'd4, r); check("R4 read launch received", r[1:0], 1);
    wr(3'd1, 8'hE0);
    rd(3'd3, r); check("R4 received byte", r, 8'h5A);
    repeat (3) @(negedge clk);
    rd(3'd4, r); check("R4 output-direction read starts nothing", r[3:2], 2'b10);

    xfer(8'h66, 8'h99, 1'b0, 1'b0, srx, per);
    wr(3'd1, 8'hE2);
    rd(3'd4, r); check("R8 clear empties", r, 8'h08);
    wr(3'd3, 8'h77);
    repeat (3) @(negedge clk);
    rd(3'd4, r); check("R8 no start while clearing", r, 8'h08);
    check("R8 sck quiet", sck_o, 0);

    wr(3'd1, 8'hE4);
    check("R10 two-wire mosi_oe", mosi_oe, 0);
    check("R10 sck_oe", sck_oe, 1);
    check("R10 miso_oe", miso_oe, 1);
    wr(3'd1, 8'h00);
    check("R10 enables off", {sck_oe, mosi_oe, miso_oe}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule